// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the transmit half of a bus-master network engine. Software builds a ring of four-word descriptors in memory and programs the ring start address. It then hands descriptors to the hardware by setting their ownership bit and writing the poll-demand strobe. The engine reads the current descriptor. If the device owns it, the engine reads the referenced buffer and sends it out byte by byte. It then writes the first descriptor word back with ownership cleared and moves to the next slot.

A descriptor holds status in word 0, control and length in word 1, and the buffer pointer in word 2. The engine keeps running from slot to slot while the enable pin is high. It stops and waits when it meets a descriptor that the host still owns. The next slot is either 16 bytes further on or, after a slot marked end-of-ring, the ring start again.

Memory is reached through one word-wide request port. A request is held until `mem_gnt`, and each accepted read returns one word later on `mem_rvalid`. Only one read is outstanding at a time. The byte output is valid/ready. A byte with its `tx_last` flag stays on the pins, unchanged, until a cycle in which `tx_ready` is high, and then it is consumed. Back-pressure only stretches the transfer; it never drops or repeats a byte.

Top module: `txring_fetch`

## Requirements
- R1: After reset `mem_req`, `tx_valid` and `tx_done` are low, and the ring position is the ring start.
- R2: A `poll_wr` pulse with `tx_en` high starts a read of word 0 at `ring_base` plus the current offset. `mem_req` for that read is high in the cycle after the second rising edge following the pulse.
- R3: If word 0 bit 31 is 0 (host owned), the engine makes no further access and no write-back. It stays at that same slot until the next poll demand. A poll that arrives while the engine is busy is remembered.
- R4: While `tx_en` is low, no descriptor is fetched. A poll demand seen while disabled is kept and is acted on once `tx_en` rises.
- R5: The buffer at the word-aligned address in word 2 is sent least significant byte first. The byte count is word 1 bits 10:0, and a count of 0 sends no bytes.
- R6: `tx_last` is high only on the final byte of a descriptor whose word 1 bit 30 (last segment) is set.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R8: The write-back of word 0 has bit 31 clear. Bit 15 is the error flag and all other bits are 0. It is the last write for the descriptor, and `tx_done` is high for exactly the one cycle after that write is accepted.
- R9: A descriptor with word 1 bit 24 set sends no bytes and is written back as 0x00008000.
- R10: After a descriptor with word 1 bit 25 set, the next slot is `ring_base`. Otherwise the next slot is 16 bytes on. The ring start must be 16-byte aligned.
- R11: After a write-back, and while `tx_en` is high, the engine fetches the next slot without a new poll demand.
- R12: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stable until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Ring start address, 16-byte aligned |
| tx_en | input | 1 | Transmit enable from the operation-mode register |
| poll_wr | input | 1 | One-cycle strobe for a write to the poll-demand register |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a last segment |
| tx_done | output | 1 | One-cycle pulse per completed descriptor |

## Verification
The word-0 request is due in the cycle after the second rising edge following a poll strobe. The bench samples `mem_req` and `mem_addr` on the falling edge right after that second edge. `tx_done` is due one cycle after the write-back grant, so the bench samples it on falling edges and compares the address of the last write accepted with the slot it expects. That covers both ordering and ring wrap. Bytes, last flags, held values under back-pressure and write-back status are collected on falling edges and compared once the expected number of done pulses has arrived. Grant and ready are randomized, so these checks follow handshakes rather than fixed cycle counts.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int OWN_BIT  = 31;
  localparam int ERR_BIT  = 15;
  localparam int LAST_BIT = 30;
  localparam int EOR_BIT  = 25;
  localparam int CHN_BIT  = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD0W, S_RD1, S_RD1W, S_RD2, S_RD2W,
    S_BRD, S_BRDW, S_BOUT, S_WB, S_DONE
  } fetch_st_e;
endpackage

// File: rtl/txr_ring.sv
module txr_ring #(
  parameter int OFS_W = 12,
  parameter int STEP  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wrap,
  output logic [OFS_W-1:0] ofs
);
  localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)    ofs <= '0;
    else if (adv)  ofs <= wrap ? '0 : ofs + STEP_V;
  end
endmodule

// File: rtl/txr_ser.sv
module txr_ser #(
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld,
  input  logic [DW-1:0]              ld_word,
  input  logic [$clog2(DW/8+1)-1:0]  ld_cnt,
  input  logic                       ld_last,
  input  logic                       out_ready,
  output logic                       out_valid,
  output logic [7:0]                 out_data,
  output logic                       out_last,
  output logic                       busy
);
  localparam int CW = $clog2(DW/8+1);

  logic [DW-1:0] word_q;
  logic [CW-1:0] cnt_q;
  logic          last_q;

  assign out_valid = (cnt_q != '0);
  assign busy      = out_valid;
  assign out_data  = word_q[7:0];
  assign out_last  = last_q && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (ld) begin
      word_q <= ld_word;
      cnt_q  <= ld_cnt;
      last_q <= ld_last;
    end else if (out_valid && out_ready) begin
      word_q <= word_q >> 8;
      cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int OFS_W = 12,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          tx_en,
  input  logic          poll_wr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_done
);
  localparam int BYTES = DW / 8;
  localparam int CW    = $clog2(BYTES + 1);
  localparam logic [AW-1:0]    WSTEP = AW'(BYTES);
  localparam logic [LEN_W-1:0] BYTES_L = LEN_W'(BYTES);

  fetch_st_e        st_q;
  logic [DW-1:0]    ctrl_q;
  logic [AW-1:0]    bufp_q;
  logic [LEN_W-1:0] rem_q;
  logic             err_q;
  logic             pend_q;
  logic [OFS_W-1:0] ofs;
  logic [AW-1:0]    desc_addr;
  logic             ser_busy;
  logic             ld;
  logic [CW-1:0]    ld_cnt;
  logic             ld_last;
  logic             gnt_ok;
  logic [LEN_W-1:0] len_w1;

  assign desc_addr = ring_base + AW'(ofs);
  assign mem_req   = (st_q == S_RD0) || (st_q == S_RD1) || (st_q == S_RD2) ||
                     (st_q == S_BRD) || (st_q == S_WB);
  assign mem_we    = (st_q == S_WB);
  assign mem_wdata = err_q ? (DW'(1) << ERR_BIT) : '0;
  assign gnt_ok    = mem_req && mem_gnt;
  assign tx_done   = (st_q == S_DONE);
  assign len_w1    = ctrl_q[LEN_W-1:0];

  always_comb begin
    case (st_q)
      S_RD1:   mem_addr = desc_addr + AW'(4);
      S_RD2:   mem_addr = desc_addr + AW'(8);
      S_BRD:   mem_addr = bufp_q;
      default: mem_addr = desc_addr;
    endcase
  end

  assign ld      = (st_q == S_BRDW) && mem_rvalid;
  assign ld_cnt  = (rem_q >= BYTES_L) ? CW'(BYTES) : CW'(rem_q);
  assign ld_last = ctrl_q[LAST_BIT] && (rem_q <= BYTES_L);

  txr_ring #(.OFS_W(OFS_W), .STEP(4 * BYTES)) u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (st_q == S_DONE),
    .wrap (ctrl_q[EOR_BIT]),
    .ofs  (ofs)
  );

  txr_ser #(.DW(DW)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .ld_word  (mem_rdata),
    .ld_cnt   (ld_cnt),
    .ld_last  (ld_last),
    .out_ready(tx_ready),
    .out_valid(tx_valid),
    .out_data (tx_data),
    .out_last (tx_last),
    .busy     (ser_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      ctrl_q <= '0;
      bufp_q <= '0;
      rem_q  <= '0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (poll_wr) pend_q <= 1'b1;
      case (st_q)
        S_IDLE: if (pend_q && tx_en) begin
          st_q <= S_RD0;
          if (!poll_wr) pend_q <= 1'b0;
        end
        S_RD0:  if (gnt_ok) st_q <= S_RD0W;
        S_RD0W: if (mem_rvalid) st_q <= mem_rdata[OWN_BIT] ? S_RD1 : S_IDLE;
        S_RD1:  if (gnt_ok) st_q <= S_RD1W;
        S_RD1W: if (mem_rvalid) begin
          ctrl_q <= mem_rdata;
          st_q   <= S_RD2;
        end
        S_RD2:  if (gnt_ok) st_q <= S_RD2W;
        S_RD2W: if (mem_rvalid) begin
          bufp_q <= AW'(mem_rdata);
          rem_q  <= len_w1;
          err_q  <= ctrl_q[CHN_BIT];
          st_q   <= (ctrl_q[CHN_BIT] || len_w1 == '0) ? S_WB : S_BRD;
        end
        S_BRD:  if (gnt_ok) st_q <= S_BRDW;
        S_BRDW: if (mem_rvalid) begin
          rem_q  <= rem_q - LEN_W'(ld_cnt);
          bufp_q <= bufp_q + WSTEP;
          st_q   <= S_BOUT;
        end
        S_BOUT: if (!ser_busy) st_q <= (rem_q == '0) ? S_WB : S_BRD;
        S_WB:   if (gnt_ok) st_q <= S_DONE;
        S_DONE: begin
          err_q <= 1'b0;
          st_q  <= tx_en ? S_RD0 : S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txring_fetch_chk.sv
module txring_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_gnt,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_done
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_wb_own_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31] && (mem_wdata[14:0] == 15'd0) && (mem_wdata[31:16] == 16'd0));

  p_done_after_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(mem_req && mem_we && mem_gnt));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  p_wb_slot_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[3:0] == 4'd0);

  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);
endmodule

bind txring_fetch txring_fetch_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_gnt  (mem_gnt),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_last  (tx_last),
  .tx_done  (tx_done)
);

// File: tb/tb_txring_fetch.sv
module tb_txring_fetch;
  localparam logic [31:0] BASE = 32'h100;
  localparam int NSLOT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0;
  logic poll_wr = 1'b0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_gnt = 1'b0;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic tx_valid, tx_last, tx_done;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  txring_fetch dut (
    .clk(clk), .rst_n(rst_n), .ring_base(BASE), .tx_en(tx_en), .poll_wr(poll_wr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_done(tx_done)
  );

  int checks = 0;
  int bad = 0;
  int done_cnt = 0;
  int wr_cnt = 0;
  int cycles = 0;
  int exp_slot = 0;
  logic [31:0] mem [1024];
  logic [31:0] last_wr_addr = '0;
  byte unsigned exp_b[$];
  bit exp_l[$];
  byte unsigned got_b[$];
  bit got_l[$];
  logic [31:0] exp_st [NSLOT];
  bit st_pend [NSLOT];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: random grant, one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_gnt  <= ($urandom % 4) != 0;
    tx_ready <= ($urandom % 3) != 0;
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        last_wr_addr <= mem_addr;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[11:2]];
      end
    end
  end

  // collector and handshake checks on falling edges
  bit prev_stall = 0;
  logic [7:0] prev_d;
  bit prev_l;
  bit prev_rstall = 0;
  logic [31:0] prev_a;
  bit prev_we;
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (prev_stall) chk(tx_valid && tx_data == prev_d && tx_last == prev_l, "R7", tx_data, prev_d);
      if (prev_rstall) chk(mem_req && mem_addr == prev_a && mem_we == prev_we, "R12", mem_addr, prev_a);
      prev_stall = tx_valid && !tx_ready;
      prev_d = tx_data; prev_l = tx_last;
      prev_rstall = mem_req && !mem_gnt;
      prev_a = mem_addr; prev_we = mem_we;
      if (tx_valid && tx_ready) begin
        got_b.push_back(tx_data);
        got_l.push_back(tx_last);
      end
      if (tx_done) begin
        done_cnt++;
        // R8/R10: last write before done is the word 0 of the expected slot
        chk(last_wr_addr == BASE + 32'(16 * exp_slot), "R10", last_wr_addr, BASE + 32'(16 * exp_slot));
        exp_slot = (exp_slot + 1) % NSLOT;
      end
    end
  end

  function automatic logic [31:0] buf_addr(input int i);
    return 32'h400 + 32'(i * 128);
  endfunction

  function automatic logic [31:0] ctrl_word(input int i, input int len, input bit ls, input bit ch);
    return (32'(ls) << 30) | (32'h1 << 29) | ((i == NSLOT - 1) ? (32'h1 << 25) : 32'h0) |
           (32'(ch) << 24) | 32'(len);
  endfunction

  task automatic give(input int i, input int len, input bit ls, input bit ch);
    int w0 = (BASE >> 2) + 4 * i;
    int bw = buf_addr(i) >> 2;
    mem[w0] = 32'h8000_0000;
    mem[w0 + 1] = ctrl_word(i, len, ls, ch);
    mem[w0 + 2] = buf_addr(i);
    for (int k = 0; k < 32; k++) mem[bw + k] = $urandom;
    if (!ch)
      for (int b = 0; b < len; b++) begin
        exp_b.push_back(8'(mem[bw + b / 4] >> (8 * (b % 4))));
        exp_l.push_back(ls && b == len - 1);
      end
    exp_st[i] = ch ? 32'h0000_8000 : 32'h0;
    st_pend[i] = 1;
  endtask

  task automatic poll(input bit check_req);
    @(negedge clk); poll_wr = 1'b1;
    @(negedge clk); poll_wr = 1'b0;
    @(negedge clk);
    if (check_req)
      chk(mem_req && !mem_we && mem_addr == BASE + 32'(16 * exp_slot), "R2", mem_addr,
          BASE + 32'(16 * exp_slot));
  endtask

  task automatic wait_done(input int target, input string req);
    int n = 0;
    while (done_cnt < target && n < 5000) begin @(negedge clk); n++; end
    chk(done_cnt == target, req, done_cnt, target);
  endtask

  task automatic settle_and_check(input string req);
    int base_done = done_cnt;
    repeat (40) @(negedge clk);
    chk(done_cnt == base_done, "R3", done_cnt, base_done);
    chk(got_b.size() == exp_b.size(), req, got_b.size(), exp_b.size());
    for (int k = 0; k < exp_b.size() && k < got_b.size(); k++) begin
      chk(got_b[k] == exp_b[k], "R5", got_b[k], exp_b[k]);
      chk(got_l[k] == exp_l[k], "R6", got_l[k], exp_l[k]);
    end
    for (int i = 0; i < NSLOT; i++)
      if (st_pend[i]) begin
        chk(mem[(BASE >> 2) + 4 * i] == exp_st[i], exp_st[i] != 0 ? "R9" : "R8",
            mem[(BASE >> 2) + 4 * i], exp_st[i]);
        st_pend[i] = 0;
      end
    got_b.delete(); got_l.delete(); exp_b.delete(); exp_l.delete();
  endtask

  initial begin
    int target;
    int slot;
    void'($urandom(32'd1234));
    for (int k = 0; k < 1024; k++) mem[k] = '0;
    for (int i = 0; i < NSLOT; i++) begin
      mem[(BASE >> 2) + 4 * i + 1] = ctrl_word(i, 0, 0, 0);
      st_pend[i] = 0;
      exp_st[i] = '0;
    end
    repeat (5) @(negedge clk);
    chk(!mem_req && !tx_valid && !tx_done, "R1", {mem_req, tx_valid, tx_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !tx_done, "R1", {mem_req, tx_done}, 0);

    // host-owned first slot: engine suspends, writes nothing
    tx_en = 1'b1;
    poll(1);
    repeat (40) @(negedge clk);
    chk(wr_cnt == 0 && done_cnt == 0, "R3", wr_cnt, 0);

    // two slots handed over, third still host owned (auto advance R11)
    give(0, 9, 1, 0);
    give(1, 4, 0, 0);
    poll(1);
    wait_done(2, "R11");
    settle_and_check("R5");

    // zero length and unsupported chained slot, the latter ends the ring
    give(2, 0, 1, 0);
    give(3, 17, 1, 1);
    poll(1);
    wait_done(4, "R9");
    settle_and_check("R9");
    chk(exp_slot == 0, "R10", exp_slot, 0);

    // disabled engine keeps the poll pending
    tx_en = 1'b0;
    give(0, 6, 1, 0);
    poll(0);
    repeat (40) @(negedge clk);
    chk(done_cnt == 4 && mem[BASE >> 2] == 32'h8000_0000, "R4", done_cnt, 4);
    tx_en = 1'b1;
    wait_done(5, "R4");
    settle_and_check("R4");

    // random rounds across the wrap
    target = 5;
    for (int r = 0; r < 8; r++) begin
      int k = 1 + ($urandom % 3);
      slot = exp_slot;
      for (int j = 0; j < k; j++) begin
        give((slot + j) % NSLOT, 1 + ($urandom % 100), 1'($urandom % 2), 1'($urandom % 8 == 0));
      end
      target += k;
      poll(1);
      wait_done(target, "R11");
      settle_and_check("R5");
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    checks++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule